// File: doc/BRIEF.md
# PCI Bus Master Request and Address-Phase Sequencer

This block is the front end of a PCI bus master. A local-side client asks for a transaction with one of two active-low strobes, one for a 32-bit and one for a 64-bit transfer. The sequencer then pulls the bus request low and waits until the arbiter grants the bus while the bus is idle. It then enables its output drivers, asks the client for the address and command, and drives one address phase. FRAME# is asserted in that phase, and REQ64# is asserted as well when a 64-bit transfer was asked for.

The block captures the byte enables once, at the end of the address phase, and drives them on the command/byte-enable lines for the rest of the transaction. Later changes on the client's input have no effect. A three-bit status vector tells the client that the bus is requested, that it is granted, and that the address phase is running. The address-phase bit is left clear when the grant was taken away too soon. After the address phase the block gives a one-cycle start pulse to a separate data-phase engine. It keeps the bus drivers on until that engine reports completion.

Top module: `pcim_addr_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a request arrives, the outputs are: request high, output enable low, FRAME# high, REQ64# high, address acknowledge high, status 3'b000, start pulse low.
- R2: In the idle state, a low level on either request strobe makes the bus request go low, with status 3'b001 (bit 0 = requesting), from the next clock edge on.
- R3: In the requesting state the block stays put, with request low, output enable low and status 3'b001, in every cycle where GNT# is high or the bus is busy (FRAME# input low or IRDY# input low).
- R4: A cycle in the requesting state in which GNT# is low and both FRAME# and IRDY# inputs are high is followed by exactly one driver-enable cycle. In that cycle the output enable is high, the address acknowledge is low and the status is 3'b011 (bit 1 = granted).
- R5: The address and command present on the local inputs during the driver-enable cycle are captured at its end and driven on the AD and CBE outputs in the address-phase cycle that follows.
- R6: In the address-phase cycle FRAME# is low and the bus request is still low. REQ64# is low only if the transaction was started with the 64-bit strobe. Status bits 0 and 1 are set.
- R7: The byte enables present on the local CBE input during the address-phase cycle are driven on the CBE outputs in every later cycle of that transaction. Changes on the local CBE input after the address phase do not alter them.
- R8: Status bit 2 is set in the address-phase cycle only if GNT# was sampled low on each of the last GNT_MIN rising edges (default 2) up to and including the edge that enters that cycle. Otherwise it stays clear, and the address phase still runs.
- R9: The cycle after the address phase carries a one-cycle start pulse. In it the bus request is released, FRAME# and REQ64# are high, the status is 3'b000 and the output enable stays high.
- R10: After the start pulse the block waits, ignoring request strobes, until the data-done input is sampled high. From the next edge on it is idle, with the output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lcl_req32_n | input | 1 | Local 32-bit transaction request strobe, active low |
| lcl_req64_n | input | 1 | Local 64-bit transaction request strobe, active low |
| lcl_ad_i | input | AW | Local address input |
| lcl_cbe_i | input | CW | Local command input, then byte-enable input |
| lcl_addr_ack_n | output | 1 | Address/command request to the client, active low |
| lcl_status | output | 3 | Progress: bit 0 requesting, bit 1 granted, bit 2 address phase |
| data_start | output | 1 | One-cycle pulse that starts the data-phase engine |
| data_done | input | 1 | Data-phase engine has finished |
| pci_gnt_n | input | 1 | Arbiter grant, active low |
| pci_frame_in_n | input | 1 | Observed FRAME#, active low |
| pci_irdy_in_n | input | 1 | Observed IRDY#, active low |
| pci_req_n | output | 1 | Bus request to the arbiter, active low |
| pci_oe | output | 1 | Output enable for the tri-state bus drivers |
| pci_frame_n | output | 1 | FRAME# drive value, active low |
| pci_req64_n | output | 1 | REQ64# drive value, active low |
| pci_ad_o | output | AW | AD drive value |
| pci_cbe_o | output | CW | Command in the address phase, byte enables afterwards |

## Verification
All outputs are decoded from registered state, so each result appears a fixed number of edges after the stimulus that causes it. The request shows one edge after the strobe. The driver-enable cycle comes one edge after the first granted idle cycle, the address phase one edge later, and the start pulse and held byte enables one edge after that. Idle returns one edge after data-done is seen. Each driver task works out these cycle numbers from its own stimulus and pushes the expected output vector for each cycle into a queue before driving anything. The monitor samples at the falling edge and compares only the entries due in the current cycle. This includes the late-grant, busy-bus, short-grant and ignored-strobe cases.

// File: rtl/pcim_seq_pkg.sv
package pcim_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_REQ   = 3'd1,
    SQ_DRV   = 3'd2,
    SQ_ADDR  = 3'd3,
    SQ_START = 3'd4,
    SQ_WAIT  = 3'd5
  } seq_state_e;

  localparam int STAT_W       = 3;
  localparam int STAT_REQUEST = 0;
  localparam int STAT_GRANTED = 1;
  localparam int STAT_ADDRPH  = 2;

endpackage

// File: rtl/pcim_rst_sync.sv
module pcim_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pcim_grant_tracker.sv
module pcim_grant_tracker #(
  parameter int GNT_MIN = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic gnt_n,
  output logic grant_held
);

  localparam int CNTW = $clog2(GNT_MIN + 1);
  localparam logic [CNTW-1:0] CNT_MAX = CNTW'(GNT_MIN);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = gnt_n || (cnt_q != CNT_MAX);
    if (gnt_n) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign grant_held = (cnt_q == CNT_MAX);

  // R8: a released grant clears the hold indication on the next edge
  a_r8_clear_on_release: assert property (@(posedge clk) disable iff (!rst_ni)
    gnt_n |=> !grant_held);

  // R8: once held, a continuing grant keeps the indication
  a_r8_hold_saturates: assert property (@(posedge clk) disable iff (!rst_ni)
    (grant_held && !gnt_n) |=> grant_held);

endmodule

// File: rtl/pcim_seq_fsm.sv
module pcim_seq_fsm
  import pcim_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       req32_n,
  input  logic       req64_n,
  input  logic       gnt_n,
  input  logic       frame_in_n,
  input  logic       irdy_in_n,
  input  logic       data_done,
  output logic       bus_req_n,
  output logic       drv_oe,
  output logic       frame_n,
  output logic       req64_out_n,
  output logic       addr_ack_n,
  output logic       start_pulse,
  output logic       addr_phase,
  output logic [1:0] stat_base,
  output logic       addr_cap_en,
  output logic       be_cap_en
);

  seq_state_e state_q, state_d;
  logic       wide_q, wide_en;
  logic       start_req, bus_idle, grant_ok;

  assign start_req = !req32_n || !req64_n;
  assign bus_idle  = frame_in_n && irdy_in_n;
  assign grant_ok  = !gnt_n && bus_idle;
  assign wide_en   = (state_q == SQ_IDLE) && start_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:  if (start_req) state_d = SQ_REQ;
      SQ_REQ:   if (grant_ok)  state_d = SQ_DRV;
      SQ_DRV:   state_d = SQ_ADDR;
      SQ_ADDR:  state_d = SQ_START;
      SQ_START: state_d = SQ_WAIT;
      SQ_WAIT:  if (data_done) state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q <= 1'b0;
    end else if (wide_en) begin
      wide_q <= !req64_n;
    end
  end

  always_comb begin
    bus_req_n   = 1'b1;
    drv_oe      = 1'b0;
    frame_n     = 1'b1;
    req64_out_n = 1'b1;
    addr_ack_n  = 1'b1;
    start_pulse = 1'b0;
    addr_phase  = 1'b0;
    stat_base   = 2'b00;
    addr_cap_en = 1'b0;
    be_cap_en   = 1'b0;
    unique case (state_q)
      SQ_REQ: begin
        bus_req_n = 1'b0;
        stat_base = 2'b01;
      end
      SQ_DRV: begin
        bus_req_n   = 1'b0;
        drv_oe      = 1'b1;
        addr_ack_n  = 1'b0;
        stat_base   = 2'b11;
        addr_cap_en = 1'b1;
      end
      SQ_ADDR: begin
        bus_req_n   = 1'b0;
        drv_oe      = 1'b1;
        frame_n     = 1'b0;
        req64_out_n = !wide_q;
        addr_phase  = 1'b1;
        stat_base   = 2'b11;
        be_cap_en   = 1'b1;
      end
      SQ_START: begin
        drv_oe      = 1'b1;
        start_pulse = 1'b1;
      end
      SQ_WAIT: begin
        drv_oe = 1'b1;
      end
      default: begin
        bus_req_n = 1'b1;
      end
    endcase
  end

  // R2: a strobe in idle raises the request on the next edge
  a_r2_req_follows_strobe: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == SQ_IDLE && start_req) |=> (!bus_req_n && stat_base == 2'b01));

  // R3: no grant or busy bus keeps the block requesting with drivers off
  a_r3_hold_without_grant: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == SQ_REQ && !grant_ok) |=> (!bus_req_n && !drv_oe));

  // R4: the address acknowledge lasts one cycle
  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_ni)
    !addr_ack_n |=> addr_ack_n);

  // R6: the address phase follows the acknowledge with request still low
  a_r6_frame_after_ack: assert property (@(posedge clk) disable iff (!rst_ni)
    !addr_ack_n |=> (!frame_n && !bus_req_n));

  // R9: the start pulse is a single cycle and follows the address phase
  a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_ni)
    !frame_n |=> (start_pulse && bus_req_n) ##1 !start_pulse);

  // R10: drivers stay on until completion is seen
  a_r10_wait_done: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == SQ_WAIT && !data_done) |=> drv_oe);

endmodule

// File: rtl/pcim_addr_capture.sv
module pcim_addr_capture #(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          addr_cap_en,
  input  logic          be_cap_en,
  input  logic          addr_phase,
  input  logic [AW-1:0] ad_i,
  input  logic [CW-1:0] cbe_i,
  output logic [AW-1:0] ad_o,
  output logic [CW-1:0] cbe_o
);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cmd_q;
  logic [CW-1:0] be_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (addr_cap_en) begin
      addr_q <= ad_i;
      cmd_q  <= cbe_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      be_q <= '0;
    end else if (be_cap_en) begin
      be_q <= cbe_i;
    end
  end

  assign ad_o  = addr_q;
  assign cbe_o = addr_phase ? cmd_q : be_q;

  // R7: byte enables change only at their capture edge
  a_r7_be_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !be_cap_en |=> $stable(be_q));

  // R5: the address changes only at its capture edge
  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !addr_cap_en |=> $stable(addr_q));

endmodule

// File: rtl/pcim_addr_seq.sv
module pcim_addr_seq
  import pcim_seq_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 4,
  parameter int GNT_MIN = 2,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcl_req32_n,
  input  logic              lcl_req64_n,
  input  logic [AW-1:0]     lcl_ad_i,
  input  logic [CW-1:0]     lcl_cbe_i,
  output logic              lcl_addr_ack_n,
  output logic [STAT_W-1:0] lcl_status,
  output logic              data_start,
  input  logic              data_done,
  input  logic              pci_gnt_n,
  input  logic              pci_frame_in_n,
  input  logic              pci_irdy_in_n,
  output logic              pci_req_n,
  output logic              pci_oe,
  output logic              pci_frame_n,
  output logic              pci_req64_n,
  output logic [AW-1:0]     pci_ad_o,
  output logic [CW-1:0]     pci_cbe_o
);

  logic       rst_ni;
  logic       grant_held;
  logic       addr_phase;
  logic [1:0] stat_base;
  logic       addr_cap_en;
  logic       be_cap_en;

  pcim_rst_sync #(.STAGES(SYNC_N)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  pcim_grant_tracker #(.GNT_MIN(GNT_MIN)) u_grant (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .gnt_n      (pci_gnt_n),
    .grant_held (grant_held)
  );

  pcim_seq_fsm u_fsm (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .req32_n     (lcl_req32_n),
    .req64_n     (lcl_req64_n),
    .gnt_n       (pci_gnt_n),
    .frame_in_n  (pci_frame_in_n),
    .irdy_in_n   (pci_irdy_in_n),
    .data_done   (data_done),
    .bus_req_n   (pci_req_n),
    .drv_oe      (pci_oe),
    .frame_n     (pci_frame_n),
    .req64_out_n (pci_req64_n),
    .addr_ack_n  (lcl_addr_ack_n),
    .start_pulse (data_start),
    .addr_phase  (addr_phase),
    .stat_base   (stat_base),
    .addr_cap_en (addr_cap_en),
    .be_cap_en   (be_cap_en)
  );

  pcim_addr_capture #(.AW(AW), .CW(CW)) u_capture (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .addr_cap_en (addr_cap_en),
    .be_cap_en   (be_cap_en),
    .addr_phase  (addr_phase),
    .ad_i        (lcl_ad_i),
    .cbe_i       (lcl_cbe_i),
    .ad_o        (pci_ad_o),
    .cbe_o       (pci_cbe_o)
  );

  assign lcl_status[STAT_REQUEST] = stat_base[0];
  assign lcl_status[STAT_GRANTED] = stat_base[1];
  assign lcl_status[STAT_ADDRPH]  = addr_phase && grant_held;

  // R8: the address-phase bit needs the grant seen at the previous edge
  a_r8_status_needs_grant: assert property (@(posedge clk) disable iff (!rst_ni)
    lcl_status[STAT_ADDRPH] |-> ($past(!pci_gnt_n) && !pci_frame_n));

  // R3: drivers are never on while only requesting
  a_r3_oe_after_grant: assert property (@(posedge clk) disable iff (!rst_ni)
    (lcl_status == 3'b001) |-> !pci_oe);

endmodule

// File: tb/pcim_addr_seq_tb.sv
`timescale 1ns/1ps
module pcim_addr_seq_tb;

  typedef struct {
    int          cyc;
    logic [8:0]  ctl;
    string       tc;
    bit          chk;
    logic [31:0] ad;
    logic [3:0]  cbe;
    string       td;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        lcl_req32_n, lcl_req64_n;
  logic [31:0] lcl_ad_i;
  logic [3:0]  lcl_cbe_i;
  logic        lcl_addr_ack_n;
  logic [2:0]  lcl_status;
  logic        data_start, data_done;
  logic        pci_gnt_n, pci_frame_in_n, pci_irdy_in_n;
  logic        pci_req_n, pci_oe, pci_frame_n, pci_req64_n;
  logic [31:0] pci_ad_o;
  logic [3:0]  pci_cbe_o;

  int   cyc;
  int   n_checks;
  int   n_errors;
  exp_t sbq[$];

  pcim_addr_seq u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .lcl_req32_n    (lcl_req32_n),
    .lcl_req64_n    (lcl_req64_n),
    .lcl_ad_i       (lcl_ad_i),
    .lcl_cbe_i      (lcl_cbe_i),
    .lcl_addr_ack_n (lcl_addr_ack_n),
    .lcl_status     (lcl_status),
    .data_start     (data_start),
    .data_done      (data_done),
    .pci_gnt_n      (pci_gnt_n),
    .pci_frame_in_n (pci_frame_in_n),
    .pci_irdy_in_n  (pci_irdy_in_n),
    .pci_req_n      (pci_req_n),
    .pci_oe         (pci_oe),
    .pci_frame_n    (pci_frame_n),
    .pci_req64_n    (pci_req64_n),
    .pci_ad_o       (pci_ad_o),
    .pci_cbe_o      (pci_cbe_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Expected control vector {req, oe, frame, req64, ack, status[2:0], start}
  // st: 0 idle, 1 requesting, 2 driver enable, 3 address, 4 start, 5 wait
  function automatic logic [8:0] ctl_of(input int st, input bit wide, input bit s2);
    case (st)
      0:       return 9'b1_0_1_1_1_000_0;
      1:       return 9'b0_0_1_1_1_001_0;
      2:       return 9'b0_1_1_1_0_011_0;
      3:       return {1'b0, 1'b1, 1'b0, !wide, 1'b1, s2, 2'b11, 1'b0};
      4:       return 9'b1_1_1_1_1_000_1;
      default: return 9'b1_1_1_1_1_000_0;
    endcase
  endfunction

  task automatic push(input int c, input logic [8:0] ctl, input string tc,
                      input bit chk, input logic [31:0] a, input logic [3:0] b,
                      input string td);
    exp_t e;
    e.cyc = c; e.ctl = ctl; e.tc = tc; e.chk = chk; e.ad = a; e.cbe = b; e.td = td;
    sbq.push_back(e);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  // Monitor: compare every item due in the current cycle
  always @(negedge clk) begin
    logic [8:0] obs;
    obs = {pci_req_n, pci_oe, pci_frame_n, pci_req64_n, lcl_addr_ack_n,
           lcl_status, data_start};
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      n_checks++;
      if (e.cyc != cyc || obs !== e.ctl) begin
        n_errors++;
        $display("FAIL %s cyc=%0d ctl actual=%b expected=%b", e.tc, e.cyc, obs, e.ctl);
      end
      if (e.chk) begin
        n_checks++;
        if (pci_ad_o !== e.ad || pci_cbe_o !== e.cbe) begin
          n_errors++;
          $display("FAIL %s cyc=%0d ad/cbe actual=%h/%h expected=%h/%h",
                   e.td, e.cyc, pci_ad_o, pci_cbe_o, e.ad, e.cbe);
        end
      end
    end
  end

  task automatic to_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Driver: one transaction. blk: 0 none, 1 grant high, 2 FRAME# busy, 3 IRDY# busy
  task automatic txn(input bit wide, input logic [31:0] a, input logic [3:0] cmd,
                     input logic [3:0] be, input int gdly, input int blk,
                     input bit short_g);
    int c, d;
    c = cyc;
    d = c + 2 + gdly;
    push(c + 1, ctl_of(1, wide, 1'b0), "R2", 1'b0, '0, '0, "");
    for (int k = c + 2; k < d; k++) push(k, ctl_of(1, wide, 1'b0), "R3", 1'b0, '0, '0, "");
    push(d,     ctl_of(2, wide, 1'b0),     "R4",    1'b0, '0, '0, "");
    push(d + 1, ctl_of(3, wide, !short_g), "R6/R8", 1'b1, a, cmd, "R5");
    push(d + 2, ctl_of(4, wide, 1'b0),     "R9",    1'b1, a, be,  "R7");
    push(d + 3, ctl_of(5, wide, 1'b0),     "R10",   1'b1, a, be,  "R7");
    push(d + 4, ctl_of(5, wide, 1'b0),     "R10",   1'b1, a, be,  "R7");
    push(d + 5, ctl_of(0, wide, 1'b0),     "R10",   1'b0, '0, '0, "");
    // request strobe and blocker
    if (wide) lcl_req64_n = 1'b0; else lcl_req32_n = 1'b0;
    pci_gnt_n = 1'b0; pci_frame_in_n = 1'b1; pci_irdy_in_n = 1'b1;
    if (gdly > 0) begin
      case (blk)
        1:       pci_gnt_n = 1'b1;
        2:       pci_frame_in_n = 1'b0;
        default: pci_irdy_in_n = 1'b0;
      endcase
    end
    to_cyc(c + 1);
    lcl_req32_n = 1'b1; lcl_req64_n = 1'b1;
    to_cyc(d - 1);
    pci_gnt_n = 1'b0; pci_frame_in_n = 1'b1; pci_irdy_in_n = 1'b1;
    to_cyc(d);
    lcl_ad_i = a; lcl_cbe_i = cmd;
    if (short_g) pci_gnt_n = 1'b1;
    to_cyc(d + 1);
    lcl_cbe_i = be; lcl_ad_i = ~a;
    to_cyc(d + 2);
    lcl_cbe_i = ~be; pci_gnt_n = 1'b1;
    lcl_req32_n = 1'b0;               // R10: strobe while busy must be ignored
    to_cyc(d + 3);
    lcl_req32_n = 1'b1; lcl_cbe_i = 4'h5;
    to_cyc(d + 4);
    data_done = 1'b1;
    to_cyc(d + 5);
    data_done = 1'b0;
  endtask

  initial begin
    n_checks = 0; n_errors = 0;
    rst_n = 1'b0;
    lcl_req32_n = 1'b1; lcl_req64_n = 1'b1;
    lcl_ad_i = '0; lcl_cbe_i = '0; data_done = 1'b0;
    pci_gnt_n = 1'b1; pci_frame_in_n = 1'b1; pci_irdy_in_n = 1'b1;
    push(2, ctl_of(0, 1'b0, 1'b0), "R1", 1'b0, '0, '0, "");
    push(3, ctl_of(0, 1'b0, 1'b0), "R1", 1'b0, '0, '0, "");
    push(8, ctl_of(0, 1'b0, 1'b0), "R1", 1'b0, '0, '0, "");
    @(negedge clk);
    to_cyc(4);
    rst_n = 1'b1;
    to_cyc(10);
    txn(1'b1, 32'h1000_0040, 4'h6, 4'h0, 0, 0, 1'b0);  // 64-bit, immediate grant
    txn(1'b0, 32'hA5A5_0004, 4'h7, 4'h3, 3, 1, 1'b0);  // grant late
    txn(1'b1, 32'h0000_FFF0, 4'hC, 4'hA, 2, 2, 1'b0);  // FRAME# busy
    txn(1'b0, 32'h8765_4320, 4'hE, 4'h9, 2, 3, 1'b1);  // IRDY# busy, short grant
    txn(1'b1, 32'hDEAD_BEE8, 4'h6, 4'hF, 0, 0, 1'b1);  // short grant
    to_cyc(cyc + 3);
    if (sbq.size() != 0) begin
      n_errors++;
      $display("FAIL R10 pending items actual=%0d expected=0", sbq.size());
    end
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

endmodule